// File: doc/BRIEF.md
# Dicode Pulse-Position Line Codec

This block is a two-slot pulse-position line codec for a serial PCM stream. The transmit half takes one PCM bit at a time, paired with a strobe, and turns it into a frame two clock cycles long. The first slot of the frame is the rise slot and the second is the fall slot. A frame carries a pulse only when the data level changes: a 0-to-1 change puts a pulse in the rise slot, and a 1-to-0 change puts a pulse in the fall slot. A frame-start marker goes out together with the rise slot, so a downstream receiver can align to frames. One clock cycle equals one slot, which makes the slot rate twice the PCM bit rate.

The receive half takes a slot-rate pulse input together with a frame-start marker that comes from an external alignment stage. From the pulses it sees, it tracks the running PCM level and presents one recovered bit per frame with a one-cycle valid strobe. It flags any frame that breaks the coding rules: pulses in both slots, a rise while the level is already high, or a fall while the level is already low. These cover wrong-slot, false-alarm and erased-pulse detection errors. After an error it carries on decoding without stalling.

Top module: `dippm_codec`

## Requirements
- R1: Every accepted PCM bit (pcm_valid_i high in a cycle that is not a rise slot) produces a frame on the next two cycles. In the first of these cycles, the rise slot, tx_sync_o is 1. In the second, the fall slot, tx_sync_o is 0. When no frame is in progress, tx_pulse_o and tx_sync_o are both 0.
- R2: An accepted bit of 1 when the transmit level is 0 gives tx_pulse_o=1 in the rise slot and 0 in the fall slot. The transmit level resets to 0, so a leading 1 gives a rise pulse.
- R3: An accepted bit of 0 when the transmit level is 1 gives tx_pulse_o=0 in the rise slot and 1 in the fall slot.
- R4: An accepted bit equal to the transmit level gives no pulse in either slot of its frame.
- R5: A pcm_valid_i that arrives during a rise slot is ignored. The current frame continues unchanged, no new frame starts, and the transmit level is not updated.
- R6: A receive frame with only a rise pulse gives rx_bit_o=1. One with only a fall pulse gives rx_bit_o=0. One with no pulse repeats the previous recovered bit. The receive level resets to 0.
- R7: A receive frame with pulses in both slots raises rx_err_o. rx_bit_o repeats the previous level, and that level is kept.
- R8: A rise-only frame while the receive level is 1, or a fall-only frame while it is 0, raises rx_err_o. The level still takes the value the pulse implies (1 for a rise, 0 for a fall). All other single-pulse and no-pulse frames give rx_err_o=0.
- R9: A receive frame starts in a cycle with rx_sync_i=1 (the rise slot), and the next cycle is its fall slot. rx_bit_o, rx_err_o and a one-cycle rx_valid_o appear two cycles after the fall slot, that is, three cycles after the rise slot.
- R10: If rx_sync_i is high again in the fall slot, the partial frame is dropped and a new frame starts. rx_pulse_i outside a frame is ignored and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pcm_bit_i | input | 1 | PCM data bit to transmit |
| pcm_valid_i | input | 1 | Strobe qualifying pcm_bit_i |
| tx_pulse_o | output | 1 | Line pulse, one slot per cycle |
| tx_sync_o | output | 1 | High in the rise slot of each transmitted frame |
| rx_pulse_i | input | 1 | Received line pulse, one slot per cycle |
| rx_sync_i | input | 1 | High in the rise slot of each received frame |
| rx_bit_o | output | 1 | Recovered PCM bit |
| rx_err_o | output | 1 | Coding-rule violation in the frame just decoded |
| rx_valid_o | output | 1 | One-cycle strobe for rx_bit_o and rx_err_o |

## Verification
On every cycle, the assertions check the following:
- The transmit pulse placement for rising, falling and unchanged data.
- That a strobe arriving in a rise slot leaves the transmit level untouched.
- That a double-pulse frame or a wrong-polarity pulse raises the error flag.
- The latency from fall slot to output strobe, and that a restarted frame yields no output.

Only the bench's scenarios can show the full recovered bit sequence over long random frame streams. The same holds for the level adopted after a wrong-polarity pulse, the silence on stray pulses outside any frame, and the exact cycle in which each output appears.

// File: rtl/dippm_pkg.sv
package dippm_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RISE = 2'd1,
    SLOT_FALL = 2'd2
  } slot_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } frame_t;
endpackage

// File: rtl/dippm_enc.sv
module dippm_enc
  import dippm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic valid_i,
  output logic pulse_o,
  output logic sync_o
);
  slot_e slot_q;
  logic  level_q, rise_pend_q, fall_pend_q;
  logic  accept;

  // a new bit is taken in idle or in the fall slot, never mid-frame
  assign accept = valid_i && (slot_q != SLOT_RISE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q      <= SLOT_IDLE;
      level_q     <= 1'b0;
      rise_pend_q <= 1'b0;
      fall_pend_q <= 1'b0;
    end else if (accept) begin
      slot_q      <= SLOT_RISE;
      level_q     <= bit_i;
      rise_pend_q <= bit_i & ~level_q;
      fall_pend_q <= ~bit_i & level_q;
    end else begin
      unique case (slot_q)
        SLOT_RISE: slot_q <= SLOT_FALL;
        SLOT_FALL: slot_q <= SLOT_IDLE;
        default:   slot_q <= SLOT_IDLE;
      endcase
    end
  end

  assign pulse_o = ((slot_q == SLOT_RISE) && rise_pend_q) ||
                   ((slot_q == SLOT_FALL) && fall_pend_q);
  assign sync_o  = (slot_q == SLOT_RISE);

  AST_ENC_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bit_i && !level_q) |=> (pulse_o && sync_o) ##1 !pulse_o); // R2
  AST_ENC_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !bit_i && level_q) |=> (!pulse_o && sync_o) ##1 (pulse_o && !sync_o)); // R3
  AST_ENC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (bit_i == level_q)) |=> !pulse_o ##1 !pulse_o); // R4
  AST_ENC_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sync_o) |=> (!sync_o && $stable(level_q))); // R5
endmodule

// File: rtl/dippm_slot_collect.sv
module dippm_slot_collect
  import dippm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pulse_i,
  input  logic   sync_i,
  output logic   frame_v_o,
  output frame_t frame_o
);
  logic phase_q, rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= 1'b0;
      rise_q    <= 1'b0;
      frame_v_o <= 1'b0;
      frame_o   <= '0;
    end else begin
      frame_v_o <= 1'b0;
      if (sync_i) begin
        // a marker always restarts framing, dropping any partial frame
        phase_q <= 1'b1;
        rise_q  <= pulse_i;
      end else if (phase_q) begin
        phase_q      <= 1'b0;
        frame_v_o    <= 1'b1;
        frame_o.rise <= rise_q;
        frame_o.fall <= pulse_i;
      end
    end
  end

  AST_COL_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q && !sync_i) |=> frame_v_o); // R9
  AST_COL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !frame_v_o); // R10
endmodule

// File: rtl/dippm_rule_check.sv
module dippm_rule_check
  import dippm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   frame_v_i,
  input  frame_t frame_i,
  output logic   bit_o,
  output logic   err_o,
  output logic   valid_o
);
  // bit_o doubles as the tracked line level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o   <= 1'b0;
      err_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= frame_v_i;
      if (frame_v_i) begin
        unique case ({frame_i.rise, frame_i.fall})
          2'b11: err_o <= 1'b1;
          2'b10: begin err_o <= bit_o;  bit_o <= 1'b1; end
          2'b01: begin err_o <= ~bit_o; bit_o <= 1'b0; end
          default: err_o <= 1'b0;
        endcase
      end
    end
  end

  AST_DEC_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_v_i && frame_i.rise && frame_i.fall) |=> (valid_o && err_o && $stable(bit_o))); // R7
  AST_DEC_WRONG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_v_i && frame_i.rise && !frame_i.fall && bit_o) |=> (err_o && bit_o)); // R8
  AST_DEC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_v_i && frame_i.rise && !frame_i.fall) |=> bit_o); // R6
  AST_DEC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_v_i && !frame_i.rise && frame_i.fall) |=> !bit_o); // R6
endmodule

// File: rtl/dippm_codec.sv
module dippm_codec
  import dippm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pcm_bit_i,
  input  logic pcm_valid_i,
  output logic tx_pulse_o,
  output logic tx_sync_o,
  input  logic rx_pulse_i,
  input  logic rx_sync_i,
  output logic rx_bit_o,
  output logic rx_err_o,
  output logic rx_valid_o
);
  logic   frame_v;
  frame_t frame;

  dippm_enc u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (pcm_bit_i),
    .valid_i (pcm_valid_i),
    .pulse_o (tx_pulse_o),
    .sync_o  (tx_sync_o)
  );

  dippm_slot_collect u_collect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (rx_pulse_i),
    .sync_i    (rx_sync_i),
    .frame_v_o (frame_v),
    .frame_o   (frame)
  );

  dippm_rule_check u_check (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_v_i (frame_v),
    .frame_i   (frame),
    .bit_o     (rx_bit_o),
    .err_o     (rx_err_o),
    .valid_o   (rx_valid_o)
  );

  AST_RX_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R9
  AST_TX_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sync_o |=> !tx_sync_o); // R1
endmodule

// File: tb/dippm_codec_test.sv
module dippm_codec_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pcm_bit = 1'b0, pcm_valid = 1'b0;
  logic rx_pulse = 1'b0, rx_sync = 1'b0;
  logic tx_pulse, tx_sync, rx_bit, rx_err, rx_valid;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  int unsigned cycles = 0;
  bit done = 1'b0;
  logic tlvl = 1'b0;
  logic dlvl = 1'b0;

  always #4 clk = ~clk;

  dippm_codec uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pcm_bit_i(pcm_bit), .pcm_valid_i(pcm_valid),
    .tx_pulse_o(tx_pulse), .tx_sync_o(tx_sync),
    .rx_pulse_i(rx_pulse), .rx_sync_i(rx_sync),
    .rx_bit_o(rx_bit), .rx_err_o(rx_err), .rx_valid_o(rx_valid)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_rise(input logic b, input logic lvl);
    return b & ~lvl;
  endfunction

  function automatic logic exp_fall(input logic b, input logic lvl);
    return ~b & lvl;
  endfunction

  // entry and exit at a negedge; leaves bench in the fall slot of the frame
  task automatic send_bit(input logic b, input string req);
    logic er, ef;
    er = exp_rise(b, tlvl);
    ef = exp_fall(b, tlvl);
    tlvl = b;
    pcm_bit = b; pcm_valid = 1'b1;
    @(negedge clk);
    pcm_valid = 1'b0;
    chk(tx_sync === 1'b1, {req, " R1 rise sync"}, tx_sync, 1);
    chk(tx_pulse === er, {req, " rise slot"}, tx_pulse, er);
    @(negedge clk);
    chk(tx_sync === 1'b0, {req, " R1 fall sync"}, tx_sync, 0);
    chk(tx_pulse === ef, {req, " fall slot"}, tx_pulse, ef);
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    chk(tx_pulse === 1'b0 && tx_sync === 1'b0, req, {tx_sync, tx_pulse}, 0);
  endtask

  // drives one full receive frame and checks the output three cycles after the rise slot
  task automatic send_frame(input logic r, input logic s, input string req);
    logic eb, ee;
    if (r && s) begin eb = dlvl; ee = 1'b1; end
    else if (r) begin ee = dlvl; dlvl = 1'b1; eb = 1'b1; end
    else if (s) begin ee = ~dlvl; dlvl = 1'b0; eb = 1'b0; end
    else begin eb = dlvl; ee = 1'b0; end
    rx_sync = 1'b1; rx_pulse = r;
    @(negedge clk);
    rx_sync = 1'b0; rx_pulse = s;
    @(negedge clk);
    rx_pulse = 1'b0;
    chk(rx_valid === 1'b0, "R9 no early valid", rx_valid, 0);
    @(negedge clk);
    chk(rx_valid === 1'b1, "R9 valid timing", rx_valid, 1);
    chk(rx_bit === eb, {req, " bit"}, rx_bit, eb);
    chk(rx_err === ee, {req, " err"}, rx_err, ee);
    @(negedge clk);
    chk(rx_valid === 1'b0, "R9 single-cycle valid", rx_valid, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(tx_pulse === 1'b0 && tx_sync === 1'b0, "R1 reset tx", {tx_sync, tx_pulse}, 0);
    chk(rx_valid === 1'b0 && rx_bit === 1'b0 && rx_err === 1'b0, "R6 reset rx",
        {rx_valid, rx_bit, rx_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 idle after reset");

    // directed transmit corners
    send_bit(1'b1, "R2 leading one");
    send_bit(1'b1, "R4 repeated one");
    send_bit(1'b0, "R3 fall");
    idle_check("R1 idle gap");
    send_bit(1'b0, "R4 repeated zero");
    idle_check("R1 idle gap");

    // R5: strobe in the rise slot must be dropped
    pcm_bit = 1'b1; pcm_valid = 1'b1;
    tlvl = 1'b1;
    @(negedge clk);
    chk(tx_pulse === 1'b1 && tx_sync === 1'b1, "R2 rise before R5 probe", tx_pulse, 1);
    pcm_bit = 1'b0; pcm_valid = 1'b1;
    @(negedge clk);
    pcm_valid = 1'b0;
    chk(tx_pulse === 1'b0 && tx_sync === 1'b0, "R5 frame unchanged", tx_pulse, 0);
    idle_check("R5 no new frame");
    send_bit(1'b1, "R5 level kept at one");

    // random transmit stream with back-to-back and gapped bits
    for (int i = 0; i < 60; i++) begin
      logic b;
      b = logic'($urandom_range(0, 1));
      send_bit(b, b == tlvl ? "R4 random" : (b ? "R2 random" : "R3 random"));
      if ($urandom_range(0, 2) == 0) idle_check("R1 random gap");
    end
    @(negedge clk);

    // directed receive corners
    send_frame(1'b0, 1'b0, "R6 empty at reset");
    send_frame(1'b1, 1'b0, "R6 rise");
    send_frame(1'b0, 1'b0, "R6 hold one");
    send_frame(1'b1, 1'b0, "R8 rise at one");
    send_frame(1'b1, 1'b1, "R7 double at one");
    send_frame(1'b0, 1'b1, "R6 fall");
    send_frame(1'b0, 1'b1, "R8 fall at zero");
    send_frame(1'b1, 1'b1, "R7 double at zero");

    // R10: restart in the fall slot drops the partial frame
    rx_sync = 1'b1; rx_pulse = 1'b1;
    @(negedge clk);
    rx_sync = 1'b1; rx_pulse = 1'b0;
    @(negedge clk);
    rx_sync = 1'b0; rx_pulse = 1'b0;
    @(negedge clk);
    chk(rx_valid === 1'b0, "R10 partial frame dropped", rx_valid, 0);
    @(negedge clk);
    chk(rx_valid === 1'b1 && rx_bit === dlvl && rx_err === 1'b0, "R10 restarted frame",
        {rx_valid, rx_bit, rx_err}, {1'b1, dlvl, 1'b0});
    @(negedge clk);

    // R10: stray pulses with no marker
    rx_pulse = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rx_valid === 1'b0, "R10 stray pulse ignored", rx_valid, 0);
    end
    rx_pulse = 1'b0;
    @(negedge clk);
    send_frame(1'b0, 1'b0, "R10 level after stray");

    // random receive frames
    for (int i = 0; i < 80; i++) begin
      logic r, s;
      r = logic'($urandom_range(0, 1));
      s = logic'($urandom_range(0, 1));
      send_frame(r, s, (r && s) ? "R7 random" : "R8 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule